// File: doc/BRIEF.md
# Configurable Pad Output Cell

This cell sits between core logic and one output pad. It decides how a data bit and a drive-enable reach the pin. A static configuration word picks one of four data modes:

- a direct combinational path;
- a registered path, where a two-input function or a select-driven choice between two core bits is held in a flop, so a multiplexed address gets a whole cycle to settle;
- a double-data-rate path, where one bit is shown in the high clock phase and another in the low phase;
- a serializer, which takes a parallel word through a valid/ready handshake and drives it one bit per clock.

A polarity bit can invert whatever reaches the pin. The drive-enable follows the core enable, or its complement, or is forced on, and can pass through a flop or go straight through.

The configuration is sampled only while the synchronous active-low reset is asserted. During reset the drive-enable is held off.

The serializer input follows these rules:

- A word moves when `ser_valid_i` and `ser_ready_o` are both high at a rising edge.
- The producer must hold the word and `ser_valid_i` steady until that happens.
- `ser_ready_o` depends only on the cell's own state, never on `ser_valid_i`.
- Ready rises while the final bit of the current word is on the pin, so a producer that always has data keeps the pin busy with no idle cycle between words.

Top module: `oc_out_cell`

## Requirements
- R1: While `rst_n` is low, `pad_en_o` is 0 and `cfg_i` is captured. After reset is released, changes on `cfg_i` have no effect on either output.
- R2: The function field `cfg_i[3:2]` selects the core value: 0 gives `sel_i ? b_i : a_i`, 1 gives `a_i & b_i`, 2 gives `a_i ^ b_i`, 3 gives `a_i | b_i`.
- R3: With mode `cfg_i[1:0]` = 0 (direct), `pad_o` follows the selected core value in the same cycle, with no clock edge needed.
- R4: With mode 1 (registered), `pad_o` shows the core value sampled at the previous rising edge.
- R5: When `cfg_i[4]` is 1, `pad_o` is the complement of the value the mode would otherwise drive, in every mode and also when the serializer is idle.
- R6: The enable field `cfg_i[6:5]` sets the raw enable: 0 gives `oe_i`, 1 gives `!oe_i`, 2 gives constant 1, 3 gives constant 0.
- R7: When `cfg_i[7]` is 0, `pad_en_o` follows the raw enable in the same cycle. When it is 1, `pad_en_o` shows the raw enable sampled at the previous rising edge.
- R8: With mode 2 (DDR), `pad_o` shows `a_i` captured at the rising edge during the high phase, and `b_i` captured at the falling edge during the low phase. The function field and `sel_i` are ignored.
- R9: With mode 3 (serializer), an accepted word is driven least significant bit first, one bit per cycle. The first bit appears in the cycle after the accepting edge. With no word in flight, `pad_o` drives 0 before inversion.
- R10: `ser_ready_o` is 0 in every mode other than 3. In mode 3 it is 1 when no word is in flight or when the last bit is on the pin, so successive words leave no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; rising and falling edges are used |
| rst_n | input | 1 | Synchronous active-low reset; configuration is loaded while low |
| cfg_i | input | 8 | Configuration: [1:0] mode, [3:2] function, [4] invert, [6:5] enable mode, [7] enable register |
| a_i | input | 1 | First core data bit (rising-edge bit in DDR) |
| b_i | input | 1 | Second core data bit (falling-edge bit in DDR) |
| sel_i | input | 1 | Choice between a_i and b_i for function 0 |
| oe_i | input | 1 | Core drive-enable |
| ser_word_i | input | SER_W | Parallel word for the serializer |
| ser_valid_i | input | 1 | Serializer word is valid |
| ser_ready_o | output | 1 | Serializer can take a word at the next rising edge |
| pad_o | output | 1 | Value driven to the pad |
| pad_en_o | output | 1 | Pad drive enable, active high |

## Verification
The hardest case to reach from the ports is the hand-off between two serializer words, where a new word must be taken on the same edge that retires the last bit of the previous one. The stimulus reaches it by raising valid for the next word as soon as the final bit of the current word is on the pin. Ready is checked just after each accept and again during the final bit, and every bit of both words is checked in turn.

The DDR low phase is the other hard case, because it can only be seen between rising edges. Each DDR step is therefore sampled twice, once in the middle of each clock phase. Stimulus for the remaining modes draws random configurations and random core inputs from a fixed seed.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    M_DIRECT = 2'd0,
    M_REG    = 2'd1,
    M_DDR    = 2'd2,
    M_SER    = 2'd3
  } oc_mode_e;

  typedef enum logic [1:0] {
    F_SEL = 2'd0,
    F_AND = 2'd1,
    F_XOR = 2'd2,
    F_OR  = 2'd3
  } oc_fn_e;

  typedef enum logic [1:0] {
    E_HIGH  = 2'd0,
    E_LOW   = 2'd1,
    E_ON    = 2'd2,
    E_OFF   = 2'd3
  } oc_en_e;

  typedef struct packed {
    logic     en_reg;
    oc_en_e   en_mode;
    logic     inv;
    oc_fn_e   fn;
    oc_mode_e mode;
  } oc_cfg_t;

  localparam int CFG_W = $bits(oc_cfg_t);
endpackage

// File: rtl/oc_fn_unit.sv
module oc_fn_unit
  import oc_pkg::*;
(
  input  oc_fn_e fn,
  input  logic   a,
  input  logic   b,
  input  logic   sel,
  output logic   y
);
  always_comb begin
    unique case (fn)
      F_SEL:   y = sel ? b : a;
      F_AND:   y = a & b;
      F_XOR:   y = a ^ b;
      default: y = a | b;
    endcase
  end
endmodule

// File: rtl/oc_oe_ctrl.sv
module oc_oe_ctrl
  import oc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  oc_en_e en_mode,
  input  logic   en_reg,
  input  logic   oe_i,
  output logic   en_o
);
  logic raw_en;
  logic en_q;

  always_comb begin
    unique case (en_mode)
      E_HIGH:  raw_en = oe_i;
      E_LOW:   raw_en = ~oe_i;
      E_ON:    raw_en = 1'b1;
      default: raw_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= raw_en;
  end

  assign en_o = rst_n & (en_reg ? en_q : raw_en);
endmodule

// File: rtl/oc_ddr_out.sv
module oc_ddr_out (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_d,
  input  logic fall_d,
  output logic q
);
  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= rise_d;
  end

  always_ff @(negedge clk) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= fall_d;
  end

  assign q = clk ? rise_q : fall_q;
endmodule

// File: rtl/oc_serializer.sv
module oc_serializer #(
  parameter int SER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [SER_W-1:0] word_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             bit_o
);
  localparam int CNT_W = $clog2(SER_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SER_W);

  logic [SER_W-1:0] sh_q;
  logic [CNT_W-1:0] left_q;
  logic             take;

  assign ready_o = active & (left_q <= CNT_W'(1));
  assign take    = ready_o & valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (take) begin
      sh_q   <= word_i;
      left_q <= FULL;
    end else if (left_q != '0) begin
      sh_q   <= sh_q >> 1;
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign bit_o = (left_q != '0) & sh_q[0];
endmodule

// File: rtl/oc_out_cell.sv
module oc_out_cell
  import oc_pkg::*;
#(
  parameter int SER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             sel_i,
  input  logic             oe_i,
  input  logic [SER_W-1:0] ser_word_i,
  input  logic             ser_valid_i,
  output logic             ser_ready_o,
  output logic             pad_o,
  output logic             pad_en_o
);
  oc_cfg_t cfg_q;
  logic    core_v;
  logic    reg_q;
  logic    ddr_v;
  logic    ser_v;
  logic    pre_pad;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= oc_cfg_t'(cfg_i);
  end

  oc_fn_unit u_fn (
    .fn (cfg_q.fn),
    .a  (a_i),
    .b  (b_i),
    .sel(sel_i),
    .y  (core_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) reg_q <= 1'b0;
    else        reg_q <= core_v;
  end

  oc_ddr_out u_ddr (
    .clk   (clk),
    .rst_n (rst_n),
    .rise_d(a_i),
    .fall_d(b_i),
    .q     (ddr_v)
  );

  oc_serializer #(.SER_W(SER_W)) u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (cfg_q.mode == M_SER),
    .word_i (ser_word_i),
    .valid_i(ser_valid_i),
    .ready_o(ser_ready_o),
    .bit_o  (ser_v)
  );

  always_comb begin
    unique case (cfg_q.mode)
      M_DIRECT: pre_pad = core_v;
      M_REG:    pre_pad = reg_q;
      M_DDR:    pre_pad = ddr_v;
      default:  pre_pad = ser_v;
    endcase
  end

  assign pad_o = pre_pad ^ cfg_q.inv;

  oc_oe_ctrl u_oe (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_mode(cfg_q.en_mode),
    .en_reg (cfg_q.en_reg),
    .oe_i   (oe_i),
    .en_o   (pad_en_o)
  );
endmodule

// File: rtl/oc_out_cell_chk.sv
module oc_out_cell_chk
  import oc_pkg::*;
#(
  parameter int SER_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_i,
  input logic             a_i,
  input logic             b_i,
  input logic             sel_i,
  input logic             oe_i,
  input logic [SER_W-1:0] ser_word_i,
  input logic             ser_valid_i,
  input logic             ser_ready_o,
  input logic             pad_o,
  input logic             pad_en_o
);
  oc_cfg_t held;

  always_ff @(posedge clk) begin
    if (!rst_n) held <= oc_cfg_t'(cfg_i);
  end

  function automatic logic ref_fn(logic [1:0] f, logic a, logic b, logic s);
    case (f)
      2'd0:    return s ? b : a;
      2'd1:    return a & b;
      2'd2:    return a ^ b;
      default: return a | b;
    endcase
  endfunction

  function automatic logic ref_en(logic [1:0] m, logic oe);
    case (m)
      2'd0:    return oe;
      2'd1:    return ~oe;
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) a_r1_en_off_in_reset: assert (pad_en_o == 1'b0);
  end

  a_r3_direct_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && held.mode == M_DIRECT) |->
      pad_o == (ref_fn(held.fn, a_i, b_i, sel_i) ^ held.inv));

  a_r4_reg_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && held.mode == M_REG) |->
      pad_o == ($past(ref_fn(held.fn, a_i, b_i, sel_i)) ^ held.inv));

  a_r7_en_reg_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && held.en_reg) |->
      pad_en_o == $past(ref_en(held.en_mode, oe_i)));

  a_r6_forced_on: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && held.en_mode == E_ON && !held.en_reg) |-> pad_en_o);

  a_r9_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid_i && ser_ready_o) |=> pad_o == ($past(ser_word_i[0]) ^ held.inv));

  a_r10_ready_only_ser: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ser_ready_o) |-> held.mode == M_SER);
endmodule

bind oc_out_cell oc_out_cell_chk #(.SER_W(SER_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_i      (cfg_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .sel_i      (sel_i),
  .oe_i       (oe_i),
  .ser_word_i (ser_word_i),
  .ser_valid_i(ser_valid_i),
  .ser_ready_o(ser_ready_o),
  .pad_o      (pad_o),
  .pad_en_o   (pad_en_o)
);

// File: tb/oc_out_cell_bench.sv
module oc_out_cell_bench;
  localparam int SER_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       cfg = 8'h00;
  logic             a = 1'b0, b = 1'b0, sel = 1'b0, oe = 1'b0;
  logic [SER_W-1:0] word = '0;
  logic             valid = 1'b0;
  logic             ready, pad, pad_en;
  int               n_chk = 0;
  int               n_fail = 0;
  logic             cur_inv = 1'b0;

  always #10 clk = ~clk;

  oc_out_cell #(.SER_W(SER_W)) u_oc_out_cell (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .a_i(a), .b_i(b), .sel_i(sel),
    .oe_i(oe), .ser_word_i(word), .ser_valid_i(valid), .ser_ready_o(ready),
    .pad_o(pad), .pad_en_o(pad_en)
  );

  function automatic logic [7:0] mk(logic [1:0] m, logic [1:0] f, logic inv,
                                    logic [1:0] em, logic er);
    return {er, em, inv, f, m};
  endfunction

  function automatic logic exp_fn(logic [1:0] f, logic x, logic y, logic s);
    case (f)
      2'd0:    return s ? y : x;
      2'd1:    return x & y;
      2'd2:    return x ^ y;
      default: return x | y;
    endcase
  endfunction

  function automatic logic exp_en(logic [1:0] m, logic o);
    case (m)
      2'd0:    return o;
      2'd1:    return ~o;
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply_cfg(logic [7:0] c);
    @(posedge clk); #1;
    rst_n = 1'b0; cfg = c; oe = 1'b1; valid = 1'b0;
    cur_inv = c[4];
    @(posedge clk); @(posedge clk); #5;
    chk("R1 enable off in reset", pad_en, 1'b0);
    #1 rst_n = 1'b1;
  endtask

  task automatic drive(logic x, logic y, logic s, logic o);
    @(posedge clk); #1;
    a = x; b = y; sel = s; oe = o;
  endtask

  task automatic ser_send(logic [SER_W-1:0] w);
    word = w; valid = 1'b1;
    for (int g = 0; g < 20 && !ready; g++) @(negedge clk);
    @(posedge clk); #1;
    valid = 1'b0;
    #4;
    chk("R10 busy after accept", ready, 1'b0);
    chk("R9 bit0", pad, w[0] ^ cur_inv);
    for (int i = 1; i < SER_W; i++) begin
      @(posedge clk); #5;
      chk("R9 serial bit", pad, w[i] ^ cur_inv);
      if (i == SER_W - 1) chk("R10 ready on last bit", ready, 1'b1);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c11));

    // R3 / R2 direct select
    apply_cfg(mk(2'd0, 2'd0, 1'b0, 2'd0, 1'b0));
    drive(1'b1, 1'b0, 1'b0, 1'b1); #5;
    chk("R3 direct sel=0", pad, 1'b1);
    chk("R6 active-high", pad_en, 1'b1);
    chk("R10 ready low outside ser", ready, 1'b0);
    sel = 1'b1; #1;
    chk("R3 direct sel=1 same cycle", pad, 1'b0);

    // R1 cfg change after reset ignored
    cfg = mk(2'd1, 2'd1, 1'b1, 2'd3, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 1'b1); #5;
    chk("R1 cfg change ignored pad", pad, 1'b1);
    chk("R1 cfg change ignored en", pad_en, 1'b1);

    // R2 every function code, direct mode
    for (int f = 0; f < 4; f++) begin
      apply_cfg(mk(2'd0, 2'(f), 1'b0, 2'd2, 1'b0));
      for (int v = 0; v < 8; v++) begin
        drive(v[0], v[1], v[2], 1'b0); #5;
        chk("R2 function", pad, exp_fn(2'(f), v[0], v[1], v[2]));
      end
    end

    // R5 inversion and R6 enable modes, directed
    apply_cfg(mk(2'd0, 2'd2, 1'b1, 2'd1, 1'b0));
    drive(1'b1, 1'b0, 1'b0, 1'b1); #5;
    chk("R5 inverted xor", pad, 1'b0);
    chk("R6 active-low", pad_en, 1'b0);
    apply_cfg(mk(2'd0, 2'd0, 1'b0, 2'd3, 1'b0));
    drive(1'b0, 1'b0, 1'b0, 1'b1); #5;
    chk("R6 forced off", pad_en, 1'b0);

    // R7 registered enable lags one cycle
    apply_cfg(mk(2'd0, 2'd0, 1'b0, 2'd0, 1'b1));
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1); #5;
    chk("R7 registered enable old value", pad_en, 1'b0);
    @(posedge clk); #5;
    chk("R7 registered enable new value", pad_en, 1'b1);

    // R4 registered data lags one cycle
    apply_cfg(mk(2'd1, 2'd0, 1'b0, 2'd2, 1'b0));
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 1'b1); #5;
    chk("R4 registered old value", pad, 1'b0);
    @(posedge clk); #5;
    chk("R4 registered new value", pad, 1'b1);

    // Random configurations for modes 0 and 1
    for (int k = 0; k < 16; k++) begin
      logic [1:0] m, f, em;
      logic       inv, er;
      m = 2'($urandom_range(0, 1)); f = 2'($urandom); em = 2'($urandom);
      inv = 1'($urandom); er = 1'($urandom);
      apply_cfg(mk(m, f, inv, em, er));
      for (int it = 0; it < 12; it++) begin
        logic x, y, s, o, ev, en;
        x = 1'($urandom); y = 1'($urandom); s = 1'($urandom); o = 1'($urandom);
        ev = exp_fn(f, x, y, s) ^ inv;
        en = exp_en(em, o);
        drive(x, y, s, o); #5;
        if (m == 2'd0) chk("R3 R5 random direct", pad, ev);
        if (!er) chk("R6 R7 random direct enable", pad_en, en);
        @(posedge clk); #5;
        if (m == 2'd1) chk("R4 R5 random registered", pad, ev);
        if (er) chk("R7 random registered enable", pad_en, en);
      end
    end

    // R8 DDR: a in high phase, b in low phase; function and select ignored
    for (int p = 0; p < 2; p++) begin
      apply_cfg(mk(2'd2, 2'd1, 1'(p), 2'd2, 1'b0));
      for (int it = 0; it < 12; it++) begin
        logic x, y;
        x = 1'($urandom); y = 1'($urandom);
        drive(x, y, 1'($urandom), 1'b1);
        @(posedge clk); #5;
        chk("R8 ddr high phase", pad, x ^ p[0]);
        @(negedge clk); #5;
        chk("R8 ddr low phase", pad, y ^ p[0]);
      end
    end

    // R9 / R10 serializer, back-to-back words then idle
    for (int p = 0; p < 2; p++) begin
      apply_cfg(mk(2'd3, 2'd0, 1'(p), 2'd2, 1'b0));
      @(negedge clk);
      chk("R10 ready when empty", ready, 1'b1);
      chk("R9 R5 idle level", pad, 1'(p));
      ser_send(4'b1011);
      ser_send(4'b0110);
      for (int w = 0; w < 4; w++) ser_send(4'($urandom));
      @(posedge clk); #5;
      chk("R9 idle after last word", pad, 1'(p));
      chk("R10 ready after drain", ready, 1'b1);
    end

    // R10 valid held outside serializer mode has no effect
    apply_cfg(mk(2'd1, 2'd0, 1'b0, 2'd2, 1'b0));
    word = 4'b1111; valid = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #5;
    chk("R10 ready low in registered mode", ready, 1'b0);
    chk("R10 valid ignored pad", pad, 1'b0);
    valid = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule